// File: doc/BRIEF.md
# Three-Channel Interval Timer Host Register Front End

This block sits between a byte-wide host bus and three counter channels of an interval timer. The host reaches it through a 2-bit address. Addresses 0, 1 and 2 are the data ports of the channels, and address 3 is the control port, which accepts writes only. A control word either configures one channel or issues a capture command. A configuration sets the byte access style, the counting mode and the BCD flag. A capture command is either a single-channel count capture or a multi-channel read-back capture. Data-port writes are assembled into 16-bit load values and handed to the channel with a one-cycle strobe. Data-port reads return a status byte, a frozen count or the live count, one byte at a time.

The counter arithmetic lives outside this block. Each channel supplies its live 16-bit count, its output level and a flag that is set while a newly written count has not yet been taken up. The block drives each channel's mode and BCD setting. It also keeps, per channel, its own byte toggles for reads and writes, a one-shot count capture and a one-shot status capture.

Top module: `tmr_hostif`

## Requirements
- R1: After reset every channel is in mode 0, binary (BCD 0), word access (low byte then high byte), with both byte toggles at the first byte, no capture pending and no load strobe.
- R2: A control-port write whose bits 5:4 are non-zero configures the channel named in bits 7:6: access = bits 5:4, mode = bits 3:1, BCD = bit 0. Both byte toggles of that channel return to the first byte.
- R3: With access 1 (low byte only), a data write loads {8'h00, byte}. With access 2 (high byte only), it loads {byte, 8'h00}. The channel's load strobe is high for exactly the one cycle after the write.
- R4: With access 3 (word), the first data write is held and produces no load. The second produces a load of {second, first}.
- R5: A control write with bits 5:4 = 00 and bits 7:6 < 3 captures the live count of that channel and leaves its access, mode and BCD unchanged.
- R6: A count capture request is ignored while an earlier captured count has not been fully read.
- R7: A control write with bits 7:6 = 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 captures the count and bit 4 = 0 captures the status of each selected channel, and unselected channels are untouched.
- R8: The status byte is {out, null-count, access[1:0], mode[2:0], BCD} from bit 7 down to bit 0. A status capture is ignored while an earlier status byte is unread.
- R9: A data read returns a pending status byte first. It then returns a captured count: one byte for access 1 (low) or 2 (high), or low then high for access 3. After that the capture is released.
- R10: With nothing pending, a data read returns the live count: the low byte for access 1, the high byte for access 2, and alternating low/high for access 3. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one byte per cycle |
| rd_en | input | 1 | Host read strobe, one byte per cycle |
| addr | input | 2 | 0..2 channel data port, 3 control port |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte, valid in the cycle rd_en is high |
| live_cnt | input | 48 | Live count of each channel, channel n at [16n+15:16n] |
| chan_out | input | 3 | Output level of each channel |
| chan_null | input | 3 | Null-count flag of each channel |
| load_stb | output | 3 | One-cycle load strobe per channel |
| load_val | output | 48 | 16-bit load value per channel, channel n at [16n+15:16n] |
| chan_mode | output | 9 | Mode of each channel, channel n at [3n+2:3n] |
| chan_bcd | output | 3 | BCD select of each channel |

## Verification
The bench captures a count, moves the live count and then reads. A design that kept re-capturing, or that let a second capture overwrite the first, would return the new value where the old one is expected. Read-back commands that take status and count together check that status comes out first and that the word capture then yields both bytes. A design that ordered or released them wrongly would hand the live count back too early. The bench also issues a control word between the two bytes of a word write, and a read-back naming one channel only. The first exposes a write toggle that is not cleared. The second exposes a read-back that spills onto a neighbouring channel. A reset with a capture pending must bring the live count back.

// File: rtl/tmr_hostif_pkg.sv
package tmr_hostif_pkg;

    localparam int NUM_CH   = 3;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 2 * BYTE_W;
    localparam int MODE_W   = 3;
    localparam int ADDR_W   = 2;
    localparam int CTL_ADDR = NUM_CH;

    typedef enum logic [1:0] {
        ACC_CAPTURE = 2'd0,
        ACC_LO      = 2'd1,
        ACC_HI      = 2'd2,
        ACC_WORD    = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        CAP_NONE = 2'd0,
        CAP_LO   = 2'd1,
        CAP_HI   = 2'd2,
        CAP_WORD = 2'd3
    } cap_e;

    typedef struct packed {
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{acc: ACC_WORD, mode: '0, bcd: 1'b0};

    function automatic chan_cfg_t cfg_from_ctl(input logic [BYTE_W-1:0] w);
        chan_cfg_t c;
        c.acc  = acc_e'(w[5:4]);
        c.mode = w[3:1];
        c.bcd  = w[0];
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] make_status(input logic o, input logic nul,
                                                      input chan_cfg_t c);
        return {o, nul, c.acc, c.mode, c.bcd};
    endfunction

    function automatic cap_e cap_from_acc(input acc_e a);
        return cap_e'(a);
    endfunction

endpackage

// File: rtl/tmr_hostif_decode.sv
module tmr_hostif_decode
    import tmr_hostif_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int AW  = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [7:1]    ctl_hi,
    output logic [NCH-1:0] data_we,
    output logic [NCH-1:0] data_re,
    output logic [NCH-1:0] cfg_we,
    output logic [NCH-1:0] cnt_cap,
    output logic [NCH-1:0] sts_cap
);

    localparam logic [1:0] SEL_READBACK = 2'b11;

    logic ctl_wr;
    logic readback;
    assign ctl_wr   = wr_en && (addr == AW'(CTL_ADDR));
    assign readback = ctl_wr && (ctl_hi[7:6] == SEL_READBACK);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic sel_hit;
        logic rb_hit;
        assign sel_hit     = ctl_wr && (ctl_hi[7:6] == 2'(ch));
        assign rb_hit      = readback && ctl_hi[1 + ch];
        assign data_we[ch] = wr_en && (addr == AW'(ch));
        assign data_re[ch] = rd_en && (addr == AW'(ch));
        assign cfg_we[ch]  = sel_hit && (ctl_hi[5:4] != 2'b00);
        assign cnt_cap[ch] = (sel_hit && (ctl_hi[5:4] == 2'b00)) || (rb_hit && !ctl_hi[5]);
        assign sts_cap[ch] = rb_hit && !ctl_hi[4];
    end

    // R2
    cfg_single_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(cfg_we));
    // R7
    rb_no_cfg_chk: assert property (@(posedge clk) disable iff (rst) (|sts_cap) |-> (cfg_we == '0));

endmodule

// File: rtl/tmr_hostif_chan.sv
module tmr_hostif_chan
    import tmr_hostif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  chan_cfg_t         cfg_in,
    input  logic              cnt_cap,
    input  logic              sts_cap,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live,
    input  logic              out_lvl,
    input  logic              null_flag,
    output chan_cfg_t         cfg,
    output logic              ld_stb,
    output logic [CNT_W-1:0]  ld_val,
    output logic [BYTE_W-1:0] rd_byte
);

    logic              wr_hi;
    logic              rd_hi;
    logic [BYTE_W-1:0] hold;
    cap_e              cap;
    logic [CNT_W-1:0]  cap_val;
    logic              sts_pend;
    logic [BYTE_W-1:0] sts_byte;

    always_comb begin
        rd_byte = '0;
        if (sts_pend) begin
            rd_byte = sts_byte;
        end else if (cap != CAP_NONE) begin
            rd_byte = (cap == CAP_HI) ? cap_val[CNT_W-1:BYTE_W] : cap_val[BYTE_W-1:0];
        end else begin
            case (cfg.acc)
                ACC_HI:   rd_byte = live[CNT_W-1:BYTE_W];
                ACC_WORD: rd_byte = rd_hi ? live[CNT_W-1:BYTE_W] : live[BYTE_W-1:0];
                default:  rd_byte = live[BYTE_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= CFG_RESET;
            wr_hi    <= 1'b0;
            rd_hi    <= 1'b0;
            hold     <= '0;
            cap      <= CAP_NONE;
            cap_val  <= '0;
            sts_pend <= 1'b0;
            sts_byte <= '0;
            ld_stb   <= 1'b0;
            ld_val   <= '0;
        end else begin
            ld_stb <= 1'b0;
            if (data_re) begin
                if (sts_pend) begin
                    sts_pend <= 1'b0;
                end else if (cap != CAP_NONE) begin
                    cap <= (cap == CAP_WORD) ? CAP_HI : CAP_NONE;
                end else if (cfg.acc == ACC_WORD) begin
                    rd_hi <= !rd_hi;
                end
            end
            if (data_we) begin
                case (cfg.acc)
                    ACC_LO: begin
                        ld_stb <= 1'b1;
                        ld_val <= {{BYTE_W{1'b0}}, wdata};
                    end
                    ACC_HI: begin
                        ld_stb <= 1'b1;
                        ld_val <= {wdata, {BYTE_W{1'b0}}};
                    end
                    default: begin
                        if (!wr_hi) begin
                            hold  <= wdata;
                            wr_hi <= 1'b1;
                        end else begin
                            ld_stb <= 1'b1;
                            ld_val <= {wdata, hold};
                            wr_hi  <= 1'b0;
                        end
                    end
                endcase
            end
            if (cnt_cap && (cap == CAP_NONE)) begin
                cap_val <= live;
                cap     <= cap_from_acc(cfg.acc);
            end
            if (sts_cap && !sts_pend) begin
                sts_byte <= make_status(out_lvl, null_flag, cfg);
                sts_pend <= 1'b1;
            end
            if (cfg_we) begin
                cfg   <= cfg_in;
                wr_hi <= 1'b0;
                rd_hi <= 1'b0;
            end
        end
    end

    // R3
    ld_from_wr_chk: assert property (@(posedge clk) disable iff (rst) ld_stb |-> $past(data_we));
    // R6
    cap_hold_chk: assert property (@(posedge clk) disable iff (rst) (cap != CAP_NONE) |=> $stable(cap_val));
    // R8
    sts_hold_chk: assert property (@(posedge clk) disable iff (rst) sts_pend |=> $stable(sts_byte));
    // R9
    sts_first_chk: assert property (@(posedge clk) disable iff (rst)
        (data_re && sts_pend && !cnt_cap) |=> (!sts_pend && $stable(cap)));
    // R2
    cfg_toggle_chk: assert property (@(posedge clk) disable iff (rst) cfg_we |=> (!wr_hi && !rd_hi));

endmodule

// File: rtl/tmr_hostif.sv
module tmr_hostif
    import tmr_hostif_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [BYTE_W-1:0]        wdata,
    output logic [BYTE_W-1:0]        rdata,
    input  logic [NUM_CH*CNT_W-1:0]  live_cnt,
    input  logic [NUM_CH-1:0]        chan_out,
    input  logic [NUM_CH-1:0]        chan_null,
    output logic [NUM_CH-1:0]        load_stb,
    output logic [NUM_CH*CNT_W-1:0]  load_val,
    output logic [NUM_CH*MODE_W-1:0] chan_mode,
    output logic [NUM_CH-1:0]        chan_bcd
);

    logic [NUM_CH-1:0] data_we;
    logic [NUM_CH-1:0] data_re;
    logic [NUM_CH-1:0] cfg_we;
    logic [NUM_CH-1:0] cnt_cap;
    logic [NUM_CH-1:0] sts_cap;
    chan_cfg_t         cfg_in;
    chan_cfg_t         cfg_q   [NUM_CH];
    logic [BYTE_W-1:0] rd_bytes[NUM_CH];

    assign cfg_in = cfg_from_ctl(wdata);

    tmr_hostif_decode #(.NCH(NUM_CH), .AW(ADDR_W)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .ctl_hi  (wdata[7:1]),
        .data_we (data_we),
        .data_re (data_re),
        .cfg_we  (cfg_we),
        .cnt_cap (cnt_cap),
        .sts_cap (sts_cap)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        tmr_hostif_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (cfg_we[ch]),
            .cfg_in    (cfg_in),
            .cnt_cap   (cnt_cap[ch]),
            .sts_cap   (sts_cap[ch]),
            .data_we   (data_we[ch]),
            .data_re   (data_re[ch]),
            .wdata     (wdata),
            .live      (live_cnt[ch*CNT_W +: CNT_W]),
            .out_lvl   (chan_out[ch]),
            .null_flag (chan_null[ch]),
            .cfg       (cfg_q[ch]),
            .ld_stb    (load_stb[ch]),
            .ld_val    (load_val[ch*CNT_W +: CNT_W]),
            .rd_byte   (rd_bytes[ch])
        );
        assign chan_mode[ch*MODE_W +: MODE_W] = cfg_q[ch].mode;
        assign chan_bcd[ch]                   = cfg_q[ch].bcd;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(i)) rdata = rd_bytes[i];
        end
    end

    // R10
    ctl_no_side_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && (addr == ADDR_W'(CTL_ADDR))) |=> $stable(load_stb));

endmodule

// File: tb/tmr_hostif_tb_top.sv
module tmr_hostif_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [47:0] live_cnt;
    logic [2:0]  chan_out;
    logic [2:0]  chan_null;
    logic [2:0]  load_stb;
    logic [47:0] load_val;
    logic [8:0]  chan_mode;
    logic [2:0]  chan_bcd;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tmr_hostif dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .chan_out(chan_out),
        .chan_null(chan_null), .load_stb(load_stb), .load_val(load_val),
        .chan_mode(chan_mode), .chan_bcd(chan_bcd)
    );

    // kinds: 0 write only, 1 read and compare, 2 write expecting a load, 3 write expecting no load
    localparam int NV = 30;
    localparam logic [31:0] VEC [NV] = '{
        {2'd1, 4'd1,  2'd0, 8'h00, 16'h0034}, // R1 live low byte in word access
        {2'd1, 4'd1,  2'd0, 8'h00, 16'h0012}, // R1 then high byte
        {2'd0, 4'd2,  2'd3, 8'h14, 16'h0000}, // R2 ch0 low-only, mode 2
        {2'd2, 4'd3,  2'd0, 8'h77, 16'h0077}, // R3 low-only load
        {2'd0, 4'd2,  2'd3, 8'h67, 16'h0000}, // R2 ch1 high-only, mode 3, bcd
        {2'd2, 4'd3,  2'd1, 8'h9C, 16'h9C00}, // R3 high-only load
        {2'd0, 4'd2,  2'd3, 8'hB8, 16'h0000}, // R2 ch2 word, mode 4
        {2'd3, 4'd4,  2'd2, 8'h11, 16'h0000}, // R4 first byte held
        {2'd2, 4'd4,  2'd2, 8'h22, 16'h2211}, // R4 second byte loads
        {2'd1, 4'd10, 2'd1, 8'h00, 16'h00AB}, // R10 high-only live
        {2'd1, 4'd10, 2'd1, 8'h00, 16'h00AB}, // R10 no toggle
        {2'd1, 4'd10, 2'd0, 8'h00, 16'h0034}, // R10 low-only live
        {2'd1, 4'd10, 2'd3, 8'h00, 16'h0000}, // R10 control port reads zero
        {2'd0, 4'd7,  2'd3, 8'hEE, 16'h0000}, // R7 read-back status of all
        {2'd1, 4'd8,  2'd0, 8'h00, 16'h0094}, // R8 ch0 status
        {2'd1, 4'd9,  2'd0, 8'h00, 16'h0034}, // R9 released, live again
        {2'd1, 4'd8,  2'd1, 8'h00, 16'h0067}, // R8 ch1 status
        {2'd1, 4'd8,  2'd2, 8'h00, 16'h00B8}, // R8 ch2 status
        {2'd0, 4'd5,  2'd3, 8'h80, 16'h0000}, // R5 capture ch2
        {2'd1, 4'd5,  2'd2, 8'h00, 16'h000F}, // R5 captured low
        {2'd1, 4'd5,  2'd2, 8'h00, 16'h005A}, // R5 captured high
        {2'd1, 4'd10, 2'd2, 8'h00, 16'h000F}, // R10 live word, low first
        {2'd0, 4'd7,  2'd3, 8'hC8, 16'h0000}, // R7 read-back count+status ch2
        {2'd1, 4'd9,  2'd2, 8'h00, 16'h00B8}, // R9 status first, config kept (R5)
        {2'd1, 4'd9,  2'd2, 8'h00, 16'h000F}, // R9 count low
        {2'd1, 4'd9,  2'd2, 8'h00, 16'h005A}, // R9 count high
        {2'd1, 4'd10, 2'd2, 8'h00, 16'h005A}, // R10 live toggle resumes at high
        {2'd0, 4'd5,  2'd3, 8'h00, 16'h0000}, // R5 capture ch0
        {2'd1, 4'd9,  2'd0, 8'h00, 16'h0034}, // R9 one byte for low-only
        {2'd1, 4'd10, 2'd0, 8'h00, 16'h0034}  // R10 live after release
    };

    task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp, input string what);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input int req);
        addr = a; rd_en = 1'b1;
        #1;
        chk(req, {8'h00, rdata}, {8'h00, exp}, "read byte");
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL R1 watchdog actual=%h expected=%h", 1, 0);
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        live_cnt  = {16'h5A0F, 16'hABCD, 16'h1234};
        chan_out  = 3'b101;
        chan_null = 3'b010;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset outputs
        chk(1, {13'h0, load_stb}, 16'h0, "load strobe after reset");
        chk(1, {7'h0, chan_mode}, 16'h0, "modes after reset");
        chk(1, {13'h0, chan_bcd}, 16'h0, "bcd after reset");

        for (int i = 0; i < NV; i++) begin
            automatic logic [31:0] v = VEC[i];
            automatic int req = int'(v[29:26]);
            case (v[31:30])
                2'd1: rd(v[25:24], v[7:0], req);
                2'd2: begin
                    wr(v[25:24], v[23:16]);
                    chk(req, {13'h0, load_stb}, 16'(3'b001 << v[25:24]), "load strobe");
                    chk(req, load_val[v[25:24]*16 +: 16], v[15:0], "load value");
                end
                2'd3: begin
                    wr(v[25:24], v[23:16]);
                    chk(req, {13'h0, load_stb}, 16'h0, "no load");
                end
                default: wr(v[25:24], v[23:16]);
            endcase
        end

        // R6 second capture ignored while first unread
        wr(2'd3, 8'h40);
        live_cnt[31:16] = 16'h1111;
        wr(2'd3, 8'h40);
        rd(2'd1, 8'hAB, 6);
        rd(2'd1, 8'h11, 10);
        // R8 second status capture ignored while pending
        wr(2'd3, 8'hE4);
        chan_out[1] = 1'b1;
        wr(2'd3, 8'hE4);
        rd(2'd1, 8'h67, 8);
        rd(2'd1, 8'h11, 8);
        // R7 read-back touches only the selected channel
        wr(2'd3, 8'hE2);
        rd(2'd1, 8'h11, 7);
        rd(2'd0, 8'h94, 7);
        // R2 mode and bcd outputs
        chk(2, {13'h0, chan_mode[8:6]}, 16'h4, "ch2 mode");
        chk(2, {13'h0, chan_mode[2:0]}, 16'h2, "ch0 mode");
        chk(2, {13'h0, chan_bcd}, 16'h2, "bcd bits");
        // R2 control word clears a half-finished word write
        wr(2'd2, 8'h55);
        chk(4, {13'h0, load_stb}, 16'h0, "held byte no load");
        wr(2'd3, 8'hB8);
        wr(2'd2, 8'h66);
        chk(2, {13'h0, load_stb}, 16'h0, "toggle reset, first byte held");
        wr(2'd2, 8'h77);
        chk(2, {13'h0, load_stb}, 16'h4, "word load strobe");
        chk(2, load_val[47:32], 16'h7766, "word load value");
        // R1 reset drops a pending capture
        wr(2'd3, 8'h00);
        live_cnt[15:0] = 16'h4321;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(2'd0, 8'h21, 1);
        rd(2'd0, 8'h43, 1);
        chk(1, {7'h0, chan_mode}, 16'h0, "modes after second reset");

        done = 1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule